// File: doc/BRIEF.md
# Audio Engine Host Control Registers

This block is the host-side register bank of an audio record and playback engine that shares a disk bus with other traffic. An 8-bit microcontroller reaches it over a simple parallel memory bus with an address, write data, read data and separate read and write strobes. The bank occupies four byte locations at a base address set by a parameter. Each location is eight bits wide.

The host uses the bank to do four things:
- enable the audio function;
- choose record or playback;
- hold the engine in soft reset, start it, or put playback into skip mode;
- hand disk bus ownership to the engine for one transfer.

The engine reports back through the bank. It raises interrupt pulses, sets a header flag, signals the end of a transfer, and shows whether it is playing. The block turns these into a level interrupt to the host and into status bits.

Several register side effects are tied to the access itself. A read of offset 0 clears the pending interrupt. The header flag at offset 2 is cleared only by writing bit 1 as 1 and then as 0. The bus grant at offset 1 drops by itself when the engine finishes its transfer. At offsets 2 and 3, bit 1 means one thing when read and another when written.

Top module: `audio_host_regs`

## Requirements
- R1: After global reset the outputs are as follows:
  - `eng_enable`, `eng_mode_play`, `eng_start`, `eng_skip`, `eng_bus_req`, `eng_dir_play` and `host_irq` are 0.
  - `eng_soft_rst` is 1.
  - The header flag is clear.
- R2: A write to offset 0 sets `eng_enable` to the inverse of data bit 0 from the next cycle. Writing 0 enables the function and writing 1 disables it.
- R3: An `eng_irq_pulse` makes the interrupt pending, and `host_irq` is high from the next cycle.
  - A read of offset 0 returns the pending state in bit 0 and clears it after that cycle.
  - A pulse in the same cycle as that read keeps the interrupt pending.
- R4: A write to offset 1 loads bit 0 into `eng_bus_req`. `eng_xfer_done` clears `eng_bus_req` on the next cycle unless offset 1 is written in that cycle. A read of offset 1 returns the grant in bit 0.
- R5: A write to offset 1 loads bit 1 into `eng_dir_play` (0 means disk write for recording, 1 means disk read for playback). A read of offset 1 returns it in bit 1.
- R6: A write to offset 2 loads bit 0 into `eng_mode_play` (0 means record, 1 means playback). A read of offset 2 returns it in bit 0. No other access changes it.
- R7: The header flag works as follows:
  - `eng_hdr_set` sets it.
  - A read of offset 2 returns it in bit 1 only while in record mode, and returns 0 there in playback mode.
  - A write of offset 2 with bit 1 = 0, when the previous offset-2 write had bit 1 = 1, clears it.
  - Any other write leaves it set.
  - A set in the same cycle as a clear leaves it set.
- R8: A write to offset 3 loads bit 0 into `eng_start` and its inverse into `eng_soft_rst` from the next cycle.
- R9: A write to offset 3 loads bit 1 into `eng_skip`. A read of offset 3 returns `eng_start` in bit 0 and the live `eng_play_busy` input in bit 1.
- R10: Bits 7..2 always read as 0, and `host_rdata` is 0 when no in-window read is active. Reads and writes outside the four-byte window change no state and clear no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low global reset |
| host_addr | input | ADDR_W | Host byte address |
| host_wdata | input | 8 | Host write data |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rdata | output | 8 | Read data, valid in the read strobe cycle |
| host_irq | output | 1 | Level interrupt, high while pending |
| eng_enable | output | 1 | Audio function enable |
| eng_mode_play | output | 1 | 0 record, 1 playback |
| eng_start | output | 1 | Engine run |
| eng_soft_rst | output | 1 | Engine held in reset |
| eng_skip | output | 1 | Discard audio packets |
| eng_bus_req | output | 1 | Disk bus granted to engine |
| eng_dir_play | output | 1 | Disk transfer direction |
| eng_irq_pulse | input | 1 | Engine interrupt event |
| eng_hdr_set | input | 1 | Engine sets header flag |
| eng_xfer_done | input | 1 | Engine transfer complete |
| eng_play_busy | input | 1 | Engine is playing audio |

## Verification
Read data is combinational, so the bench samples it one time unit after driving the strobe and before the clock edge. Every register and side effect (enable, grant, mode, start, skip, the interrupt and the header flag) takes effect at the edge that ends the access. The bench compares those results at the following falling edge, exactly one cycle after the stimulus. A reference model in the bench advances once per edge using the same inputs, so a read sees the state before its own clear, and `eng_play_busy` appears in the same cycle it is driven. Directed sequences cover the collisions: interrupt pulse against read-clear, header set against toggle-clear, and transfer-done against a bus write. They also cover the single-write non-clear and out-of-window accesses.

// File: rtl/aud_pkg.sv
package aud_pkg;
    localparam int NUM_REGS = 4;
    localparam int REG_W    = 8;
    localparam int OFS_W    = $clog2(NUM_REGS);

    typedef enum logic [OFS_W-1:0] {
        OFS_CTRL = 2'd0,
        OFS_BUS  = 2'd1,
        OFS_MODE = 2'd2,
        OFS_RUN  = 2'd3
    } aud_ofs_e;

    localparam int B_LO = 0;
    localparam int B_HI = 1;

    typedef struct packed {
        logic enable;
        logic bus_req;
        logic dir_play;
        logic mode_play;
        logic hdr_wbit;
        logic start;
        logic skip;
    } aud_ctl_t;

    localparam aud_ctl_t CTL_RESET = '0;
endpackage

// File: rtl/aud_addr_dec.sv
module aud_addr_dec
    import aud_pkg::*;
#(
    parameter int                ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE   = 16'h8000
) (
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic                rd_i,
    input  logic                wr_i,
    output logic [NUM_REGS-1:0] rd_sel_o,
    output logic [NUM_REGS-1:0] wr_sel_o
);
    logic             hit;
    logic [OFS_W-1:0] ofs;

    assign hit = (addr_i[ADDR_W-1:OFS_W] == BASE[ADDR_W-1:OFS_W]);
    assign ofs = addr_i[OFS_W-1:0];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
        assign rd_sel_o[i] = hit && rd_i && (ofs == OFS_W'(i));
        assign wr_sel_o[i] = hit && wr_i && (ofs == OFS_W'(i));
    end
endmodule

// File: rtl/aud_sticky_flag.sv
module aud_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (clr_i) flag_d = 1'b0;
        if (set_i) flag_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/aud_rd_mux.sv
module aud_rd_mux
    import aud_pkg::*;
(
    input  logic [NUM_REGS-1:0] rd_sel_i,
    input  aud_ctl_t            ctl_i,
    input  logic                irq_i,
    input  logic                hdr_i,
    input  logic                play_busy_i,
    output logic [REG_W-1:0]    rdata_o
);
    always_comb begin
        rdata_o = '0;
        unique case (1'b1)
            rd_sel_i[OFS_CTRL]: rdata_o[B_LO] = irq_i;
            rd_sel_i[OFS_BUS]: begin
                rdata_o[B_LO] = ctl_i.bus_req;
                rdata_o[B_HI] = ctl_i.dir_play;
            end
            rd_sel_i[OFS_MODE]: begin
                rdata_o[B_LO] = ctl_i.mode_play;
                rdata_o[B_HI] = hdr_i & ~ctl_i.mode_play;
            end
            rd_sel_i[OFS_RUN]: begin
                rdata_o[B_LO] = ctl_i.start;
                rdata_o[B_HI] = play_busy_i;
            end
            default: rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/audio_host_regs.sv
module audio_host_regs
    import aud_pkg::*;
#(
    parameter int                ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE   = 16'h8000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [7:0]        host_wdata,
    input  logic              host_rd,
    input  logic              host_wr,
    output logic [7:0]        host_rdata,
    output logic              host_irq,
    output logic              eng_enable,
    output logic              eng_mode_play,
    output logic              eng_start,
    output logic              eng_soft_rst,
    output logic              eng_skip,
    output logic              eng_bus_req,
    output logic              eng_dir_play,
    input  logic              eng_irq_pulse,
    input  logic              eng_hdr_set,
    input  logic              eng_xfer_done,
    input  logic              eng_play_busy
);
    logic [NUM_REGS-1:0] rd_sel, wr_sel;
    aud_ctl_t            ctl_d, ctl_q;
    logic                irq_pend, hdr_flag, hdr_clr;

    aud_addr_dec #(.ADDR_W(ADDR_W), .BASE(BASE)) dec_i (
        .addr_i   (host_addr),
        .rd_i     (host_rd),
        .wr_i     (host_wr),
        .rd_sel_o (rd_sel),
        .wr_sel_o (wr_sel)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (wr_sel[OFS_CTRL]) ctl_d.enable = ~host_wdata[B_LO];
        if (wr_sel[OFS_BUS]) begin
            ctl_d.bus_req  = host_wdata[B_LO];
            ctl_d.dir_play = host_wdata[B_HI];
        end else if (eng_xfer_done) begin
            ctl_d.bus_req = 1'b0;
        end
        if (wr_sel[OFS_MODE]) begin
            ctl_d.mode_play = host_wdata[B_LO];
            ctl_d.hdr_wbit  = host_wdata[B_HI];
        end
        if (wr_sel[OFS_RUN]) begin
            ctl_d.start = host_wdata[B_LO];
            ctl_d.skip  = host_wdata[B_HI];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= CTL_RESET;
        else        ctl_q <= ctl_d;
    end

    assign hdr_clr = wr_sel[OFS_MODE] & ctl_q.hdr_wbit & ~host_wdata[B_HI];

    aud_sticky_flag irq_flag_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (eng_irq_pulse),
        .clr_i  (rd_sel[OFS_CTRL]),
        .flag_o (irq_pend)
    );

    aud_sticky_flag hdr_flag_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (eng_hdr_set),
        .clr_i  (hdr_clr),
        .flag_o (hdr_flag)
    );

    aud_rd_mux mux_i (
        .rd_sel_i    (rd_sel),
        .ctl_i       (ctl_q),
        .irq_i       (irq_pend),
        .hdr_i       (hdr_flag),
        .play_busy_i (eng_play_busy),
        .rdata_o     (host_rdata)
    );

    assign host_irq      = irq_pend;
    assign eng_enable    = ctl_q.enable;
    assign eng_mode_play = ctl_q.mode_play;
    assign eng_start     = ctl_q.start;
    assign eng_soft_rst  = ~ctl_q.start;
    assign eng_skip      = ctl_q.skip;
    assign eng_bus_req   = ctl_q.bus_req;
    assign eng_dir_play  = ctl_q.dir_play;
endmodule

// File: rtl/aud_host_regs_chk.sv
module aud_host_regs_chk #(
    parameter int                ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE   = 16'h8000
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] host_addr,
    input logic [7:0]        host_wdata,
    input logic              host_rd,
    input logic              host_wr,
    input logic [7:0]        host_rdata,
    input logic              host_irq,
    input logic              eng_enable,
    input logic              eng_mode_play,
    input logic              eng_start,
    input logic              eng_soft_rst,
    input logic              eng_bus_req,
    input logic              eng_irq_pulse,
    input logic              eng_xfer_done
);
    logic in_win;
    logic at0, at1, at2, at3;

    assign in_win = (host_addr[ADDR_W-1:2] == BASE[ADDR_W-1:2]);
    assign at0 = in_win && (host_addr[1:0] == 2'd0);
    assign at1 = in_win && (host_addr[1:0] == 2'd1);
    assign at2 = in_win && (host_addr[1:0] == 2'd2);
    assign at3 = in_win && (host_addr[1:0] == 2'd3);

    p_enable_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && at0) |=> (eng_enable == !$past(host_wdata[0])));

    p_irq_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        eng_irq_pulse |=> host_irq);

    p_irq_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && at0 && !eng_irq_pulse) |=> !host_irq);

    p_bus_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_xfer_done && !(host_wr && at1)) |=> !eng_bus_req);

    p_mode_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_wr && at2) |=> $stable(eng_mode_play));

    p_start_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && at3) |=> (eng_start == $past(host_wdata[0]) &&
                              eng_soft_rst == !$past(host_wdata[0])));

    p_high_bits_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        host_rdata[7:2] == 6'd0);

    p_outside_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_win || !host_rd) |-> (host_rdata == 8'd0));
endmodule

bind audio_host_regs aud_host_regs_chk #(.ADDR_W(ADDR_W), .BASE(BASE)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .host_addr     (host_addr),
    .host_wdata    (host_wdata),
    .host_rd       (host_rd),
    .host_wr       (host_wr),
    .host_rdata    (host_rdata),
    .host_irq      (host_irq),
    .eng_enable    (eng_enable),
    .eng_mode_play (eng_mode_play),
    .eng_start     (eng_start),
    .eng_soft_rst  (eng_soft_rst),
    .eng_bus_req   (eng_bus_req),
    .eng_irq_pulse (eng_irq_pulse),
    .eng_xfer_done (eng_xfer_done)
);

// File: tb/audio_host_regs_tb_top.sv
module audio_host_regs_tb_top;
    localparam int          ADDR_W = 16;
    localparam logic [15:0] BASE   = 16'h8000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic        host_rd = 1'b0, host_wr = 1'b0;
    logic [7:0]  host_rdata;
    logic        host_irq, eng_enable, eng_mode_play, eng_start, eng_soft_rst;
    logic        eng_skip, eng_bus_req, eng_dir_play;
    logic        eng_irq_pulse = 1'b0, eng_hdr_set = 1'b0;
    logic        eng_xfer_done = 1'b0, eng_play_busy = 1'b0;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    // reference model state
    logic m_en, m_irq, m_bus, m_dir, m_mode, m_hdr, m_wbit, m_start, m_skip;

    always #4 clk = ~clk;

    audio_host_regs #(.ADDR_W(ADDR_W), .BASE(BASE)) dut_i (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rd(host_rd), .host_wr(host_wr), .host_rdata(host_rdata),
        .host_irq(host_irq), .eng_enable(eng_enable), .eng_mode_play(eng_mode_play),
        .eng_start(eng_start), .eng_soft_rst(eng_soft_rst), .eng_skip(eng_skip),
        .eng_bus_req(eng_bus_req), .eng_dir_play(eng_dir_play),
        .eng_irq_pulse(eng_irq_pulse), .eng_hdr_set(eng_hdr_set),
        .eng_xfer_done(eng_xfer_done), .eng_play_busy(eng_play_busy)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit in_win(input logic [15:0] a);
        return a[15:2] == BASE[15:2];
    endfunction

    function automatic logic [7:0] exp_rdata(input logic [15:0] a, input logic rd,
                                             input logic busy);
        logic [7:0] r = '0;
        if (rd && in_win(a)) begin
            case (a[1:0])
                2'd0: r[0] = m_irq;
                2'd1: r[1:0] = {m_dir, m_bus};
                2'd2: r[1:0] = {m_hdr & ~m_mode, m_mode};
                default: r[1:0] = {busy, m_start};
            endcase
        end
        return r;
    endfunction

    function automatic string rd_req(input logic [15:0] a);
        if (!in_win(a)) return "R10";
        case (a[1:0])
            2'd0: return "R3";
            2'd1: return "R4";
            2'd2: return "R7";
            default: return "R9";
        endcase
    endfunction

    task automatic model_reset();
        {m_en, m_irq, m_bus, m_dir, m_mode, m_hdr, m_wbit, m_start, m_skip} = '0;
    endtask

    task automatic check_outputs();
        check(eng_enable == m_en, "R2 eng_enable", eng_enable, m_en);
        check(host_irq == m_irq, "R3 host_irq", host_irq, m_irq);
        check(eng_bus_req == m_bus, "R4 eng_bus_req", eng_bus_req, m_bus);
        check(eng_dir_play == m_dir, "R5 eng_dir_play", eng_dir_play, m_dir);
        check(eng_mode_play == m_mode, "R6 eng_mode_play", eng_mode_play, m_mode);
        check(eng_start == m_start, "R8 eng_start", eng_start, m_start);
        check(eng_soft_rst == !m_start, "R8 eng_soft_rst", eng_soft_rst, !m_start);
        check(eng_skip == m_skip, "R9 eng_skip", eng_skip, m_skip);
    endtask

    // one host/engine cycle; called at a falling edge, returns at the next one
    task automatic step(input logic [15:0] a, input logic rd, input logic wr,
                        input logic [7:0] d, input logic ip, input logic hs,
                        input logic xd, input logic pb, output logic [7:0] rdv);
        logic [7:0] er;
        logic hit;
        host_addr = a; host_rd = rd; host_wr = wr; host_wdata = d;
        eng_irq_pulse = ip; eng_hdr_set = hs; eng_xfer_done = xd; eng_play_busy = pb;
        #1;
        er = exp_rdata(a, rd, pb);
        rdv = host_rdata;
        check(host_rdata == er, {rd_req(a), " host_rdata"}, host_rdata, er);
        @(posedge clk);
        hit = in_win(a);
        if (wr && hit && a[1:0] == 2'd0) m_en = ~d[0];
        if (wr && hit && a[1:0] == 2'd1) begin m_bus = d[0]; m_dir = d[1]; end
        else if (xd) m_bus = 1'b0;
        if (wr && hit && a[1:0] == 2'd2) begin
            if (m_wbit && !d[1]) m_hdr = 1'b0;
            m_mode = d[0]; m_wbit = d[1];
        end
        if (hs) m_hdr = 1'b1;
        if (wr && hit && a[1:0] == 2'd3) begin m_start = d[0]; m_skip = d[1]; end
        if (rd && hit && a[1:0] == 2'd0) m_irq = 1'b0;
        if (ip) m_irq = 1'b1;
        @(negedge clk);
        check_outputs();
    endtask

    task automatic wr8(input logic [15:0] a, input logic [7:0] d);
        logic [7:0] x;
        step(a, 1'b0, 1'b1, d, 1'b0, 1'b0, 1'b0, 1'b0, x);
    endtask

    task automatic rd8(input logic [15:0] a, output logic [7:0] v);
        step(a, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, v);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(host_irq == 1'b0 && eng_enable == 1'b0 && eng_mode_play == 1'b0,
              "R1 irq/enable/mode", {host_irq, eng_enable, eng_mode_play}, 0);
        check(eng_start == 1'b0 && eng_soft_rst == 1'b1 && eng_skip == 1'b0,
              "R1 start/soft_rst/skip", {eng_start, eng_soft_rst, eng_skip}, 3'b010);
        check(eng_bus_req == 1'b0 && eng_dir_play == 1'b0, "R1 bus/dir",
              {eng_bus_req, eng_dir_play}, 0);
        rd8(BASE + 16'd2, v);
        check(v == 8'h00, "R1 offset 2 read", v, 0);

        // R2: enable is active-low written
        wr8(BASE, 8'h00);
        check(eng_enable == 1'b1, "R2 enable after 0", eng_enable, 1);
        wr8(BASE, 8'hFF);
        check(eng_enable == 1'b0, "R2 disable after 1", eng_enable, 0);
        wr8(BASE, 8'h00);

        // R3: pulse then read-clear colliding with new pulse
        step(BASE + 16'd3, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, v);
        step(BASE, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, v);
        check(v[0] == 1'b1, "R3 read shows pending", v, 1);
        check(host_irq == 1'b1, "R3 pulse beats read-clear", host_irq, 1);
        rd8(BASE, v);
        check(host_irq == 1'b0, "R3 read clears", host_irq, 0);

        // R7: header flag set, single write 0 does not clear
        step(BASE + 16'd1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, v);
        wr8(BASE + 16'd2, 8'h00);
        rd8(BASE + 16'd2, v);
        check(v[1] == 1'b1, "R7 single write 0 keeps flag", v, 8'h02);
        wr8(BASE + 16'd2, 8'h02);
        step(BASE + 16'd2, 1'b0, 1'b1, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, v);
        rd8(BASE + 16'd2, v);
        check(v[1] == 1'b1, "R7 set beats toggle-clear", v, 8'h02);
        wr8(BASE + 16'd2, 8'h03);
        rd8(BASE + 16'd2, v);
        check(v == 8'h01, "R7 hidden in play mode", v, 8'h01);
        wr8(BASE + 16'd2, 8'h00);
        rd8(BASE + 16'd2, v);
        check(v == 8'h00, "R7 toggle 1 then 0 clears", v, 0);

        // R4/R5: grant and auto-release, write wins over done
        wr8(BASE + 16'd1, 8'h03);
        check(eng_bus_req == 1'b1 && eng_dir_play == 1'b1, "R4 R5 grant play dir",
              {eng_bus_req, eng_dir_play}, 2'b11);
        step(BASE + 16'd1, 1'b0, 1'b1, 8'h01, 1'b0, 1'b0, 1'b1, 1'b0, v);
        check(eng_bus_req == 1'b1, "R4 write beats done", eng_bus_req, 1);
        step(BASE, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, v);
        check(eng_bus_req == 1'b0, "R4 done releases", eng_bus_req, 0);

        // R8/R9: start, skip, busy readback
        wr8(BASE + 16'd3, 8'h03);
        check(eng_start && !eng_soft_rst && eng_skip, "R8 R9 start and skip",
              {eng_start, eng_soft_rst, eng_skip}, 3'b101);
        step(BASE + 16'd3, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, v);
        check(v == 8'h03, "R9 busy readback", v, 8'h03);

        // R10: outside window ignored
        step(BASE + 16'd1, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, v);
        wr8(BASE + 16'd4, 8'hFF);
        wr8(16'h0003, 8'h00);
        rd8(BASE + 16'd4, v);
        check(v == 8'h00 && host_irq == 1'b1, "R10 outside read quiet", {v, host_irq}, 1);
        check(eng_start == 1'b1, "R10 outside write ignored", eng_start, 1);

        // constrained random traffic
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] a;
            logic [2:0]  op;
            case ($urandom % 4)
                0, 1: a = BASE + 16'($urandom % 4);
                2:    a = BASE + 16'd4 + 16'($urandom % 4);
                default: a = 16'($urandom);
            endcase
            op = 3'($urandom % 5);
            step(a, op == 3'd0 || op == 3'd1, op == 3'd2 || op == 3'd3, 8'($urandom),
                 ($urandom % 8) == 0, ($urandom % 8) == 0, ($urandom % 6) == 0,
                 1'($urandom), v);
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule